// File: doc/BRIEF.md
# Multidrop 9-bit Serial Transceiver with Receiver Wakeup

This block is an asynchronous serial transceiver for a line that several stations share. Every character travels in an 11-bit frame: one low start bit, eight data bits with the least significant bit first, a ninth bit, and one high stop bit. The ninth bit is 0 for a data character and 1 for an address character. The transmitter has two write strobes that share one character input. The strobe the host uses sets the ninth bit. The transmitter can drive the line push-pull, or it can drive it open-drain so that several transmitters can sit on one wire.

The receiver has a sleep state. While it sleeps it drops incoming characters, so the host does not have to read traffic meant for other stations. It wakes in one of two ways, selected by the host:

- **Idle-line wakeup:** it wakes after ten bit times of mark on the line, so it is awake before the next message starts.
- **Address wakeup:** it wakes on the first character whose ninth bit is 1.

An optional comparator checks each address character against an 8-bit station address:

- On a match, the receiver stays awake.
- On a mismatch, it goes back to sleep.

The host can also force sleep. A 16x oversampling tick comes from a programmable divider. The receiver samples each bit at its centre. The delivered word carries the ninth bit.

Top module: `mdrop_uart`

## Requirements
- R1: After reset, `tx_empty` is 1, `rx_full` is 0 and `rx_asleep` is 0. The transmit line is released: high with `txd_oe`=1 in push-pull mode, and `txd_oe`=0 in open-drain mode.
- R2: A pulse on `tx_data_wr` while `tx_empty` is 1 sends one frame. The frame is start 0, then `tx_char` bits 0 to 7, then a ninth bit of 0, then stop 1. Each bit lasts 16 ticks, and a tick occurs every `baud_div`+1 clocks.
- R3: A pulse on `tx_addr_wr` sends the same frame shape with the ninth bit set to 1. If both strobes arrive in the same cycle, the address strobe wins.
- R4: With `wired_mode`=1, `txd_oe` is 1 only while a 0 bit is being sent, and `txd_out` is then 0. Otherwise `txd_oe` is 0 and the line is released.
- R5: While `rx_asleep` is 1, a received character is not delivered and `rx_full` stays 0. The only exception is the address-wakeup case in R6.
- R6: With `wake_mode`=1 (address wakeup), a received character with ninth bit 1 clears `rx_asleep`. That character is delivered in `rx_word`, with the ninth bit in bit 8 and the data in bits 7 to 0.
- R7: With `wake_mode`=0 (idle wakeup), a sleeping receiver wakes once the line has been high for 10 bit times (160 ticks) while no frame is being received. The count restarts when sleep is entered.
- R8: With `match_en`=1, an address character whose data differs from `station_addr` is not delivered and puts the receiver to sleep. A matching address character is delivered, and the receiver stays awake for the data characters that follow.
- R9: A low pulse on `rxd` that is no longer low 8 ticks after it was detected is rejected as a false start. It delivers nothing, and later frames are still received.
- R10: `tx_empty` goes to 0 on the clock after a write is accepted. It returns to 1 after the stop bit. Writes made while `tx_empty` is 0 are ignored.
- R11: A pulse on `rx_ack` clears `rx_full`.
- R12: A pulse on `sleep_req` sets `rx_asleep` on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| baud_div | input | 16 | Tick divider; one tick every baud_div+1 clocks |
| tx_char | input | 8 | Character to send |
| tx_data_wr | input | 1 | Write strobe: send tx_char as data |
| tx_addr_wr | input | 1 | Write strobe: send tx_char as address |
| wired_mode | input | 1 | 1 selects open-drain drive of the transmit line |
| txd_out | output | 1 | Transmit line value |
| txd_oe | output | 1 | Transmit line output enable |
| tx_empty | output | 1 | Transmitter can take a character |
| rxd | input | 1 | Receive line (asynchronous) |
| wake_mode | input | 1 | 0 idle-line wakeup, 1 address wakeup |
| sleep_req | input | 1 | Pulse to force the receiver asleep |
| match_en | input | 1 | Enables the station address comparator |
| station_addr | input | 8 | Station address for the comparator |
| rx_ack | input | 1 | Pulse to clear rx_full |
| rx_word | output | 9 | Last delivered character; bit 8 is the ninth bit |
| rx_full | output | 1 | A delivered character is waiting |
| rx_asleep | output | 1 | Receiver is in the sleep state |

## Verification
The transmitter is checked with a data write and with an address write. The frames are decoded at the pin in both push-pull and open-drain mode, which separates the ninth-bit value from the drive style. The receiver is fed several patterns, and each one tells apart delivery, silent discard and the actual wakeup cause:

- data and address characters while awake;
- data then an address while asleep in address mode;
- a character followed by a long mark while asleep in idle mode;
- matching and mismatching addresses with the comparator on;
- a short false-start glitch.

A loopback run ties the transmitter to the receiver to confirm that both sides agree on the frame.

// File: rtl/mdrop_pkg.sv
package mdrop_pkg;
  localparam int CHAR_W     = 8;
  localparam int WORD_W     = CHAR_W + 1;
  localparam int FRAME_BITS = CHAR_W + 3;

  typedef enum logic {
    WAKE_IDLE = 1'b0,
    WAKE_ADDR = 1'b1
  } wake_mode_e;

  typedef enum logic [1:0] {
    RX_HUNT,
    RX_START,
    RX_BITS,
    RX_STOP
  } rx_state_e;

  // Frame image, sent from bit 0 upward: start, data LSB first, ninth bit, stop.
  function automatic logic [FRAME_BITS-1:0] pack_frame(input logic [CHAR_W-1:0] ch,
                                                      input logic is_addr);
    return {1'b1, is_addr, ch, 1'b0};
  endfunction

  // Ticks of continuous mark that count as an idle line.
  function automatic int idle_ticks(input int bits, input int ovs);
    return bits * ovs;
  endfunction
endpackage

// File: rtl/mdrop_baud.sv
module mdrop_baud #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;

  assign tick = (cnt >= div);

  always_ff @(posedge clk) begin
    if (!rst_n) cnt <= '0;
    else if (tick) cnt <= '0;
    else cnt <= cnt + 1'b1;
  end

  p_tick_restarts_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (cnt == '0));
endmodule

// File: rtl/mdrop_tx.sv
module mdrop_tx
  import mdrop_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              wr_data,
  input  logic              wr_addr,
  input  logic [CHAR_W-1:0] ch,
  input  logic              wired_mode,
  output logic              line_out,
  output logic              line_oe,
  output logic              empty
);
  localparam int SUB_W = $clog2(OVS);
  localparam int BC_W  = $clog2(FRAME_BITS + 1);

  logic [FRAME_BITS-1:0] shreg;
  logic                  busy;
  logic [SUB_W-1:0]      sub;
  logic [BC_W-1:0]       bitn;
  logic                  wr_any, accept, bit_end, cur_bit;

  assign wr_any  = wr_data | wr_addr;
  assign accept  = wr_any & ~busy;
  assign bit_end = busy & tick & (sub == SUB_W'(OVS - 1));
  assign cur_bit = busy ? shreg[0] : 1'b1;
  assign empty   = ~busy;

  // Open-drain style: only ever pull low, release for a 1.
  assign line_out = wired_mode ? 1'b0 : cur_bit;
  assign line_oe  = wired_mode ? ~cur_bit : 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shreg <= '1;
      busy  <= 1'b0;
      sub   <= '0;
      bitn  <= '0;
    end else if (accept) begin
      shreg <= pack_frame(ch, wr_addr);
      busy  <= 1'b1;
      sub   <= '0;
      bitn  <= '0;
    end else if (busy && tick) begin
      if (bit_end) begin
        sub   <= '0;
        shreg <= {1'b1, shreg[FRAME_BITS-1:1]};
        if (bitn == BC_W'(FRAME_BITS - 1)) busy <= 1'b0;
        else bitn <= bitn + 1'b1;
      end else begin
        sub <= sub + 1'b1;
      end
    end
  end

  p_accept_clears_empty_r10: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !empty);
  p_busy_write_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && wr_any && !bit_end) |=> $stable(shreg));
  p_wired_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wired_mode && !busy) |-> !line_oe);
endmodule

// File: rtl/mdrop_rx.sv
module mdrop_rx
  import mdrop_pkg::*;
#(
  parameter int OVS       = 16,
  parameter int IDLE_BITS = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              rxd_async,
  input  logic              idle_clear,
  output logic              frame_done,
  output logic [WORD_W-1:0] frame_word,
  output logic              idle_hit,
  output logic              start_reject
);
  localparam int SUB_W  = $clog2(OVS);
  localparam int HALF   = OVS / 2;
  localparam int IDLE_T = idle_ticks(IDLE_BITS, OVS);
  localparam int IC_W   = $clog2(IDLE_T + 1);

  logic [1:0]        sync;
  logic              rxd;
  rx_state_e         state;
  logic [SUB_W-1:0]  sub;
  logic [3:0]        bitn;
  logic [WORD_W-1:0] shreg;
  logic [IC_W-1:0]   idle_cnt;
  logic              mid_start, bit_end;

  assign rxd          = sync[1];
  assign mid_start    = (state == RX_START) && tick && (sub == SUB_W'(HALF - 1));
  assign start_reject = mid_start && rxd;
  assign bit_end      = tick && (sub == SUB_W'(OVS - 1));
  assign frame_word   = shreg;
  assign idle_hit     = tick && (state == RX_HUNT) && rxd && !idle_clear &&
                        (idle_cnt == IC_W'(IDLE_T - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) sync <= 2'b11;
    else sync <= {sync[0], rxd_async};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= RX_HUNT;
      sub        <= '0;
      bitn       <= '0;
      shreg      <= '0;
      frame_done <= 1'b0;
    end else begin
      frame_done <= 1'b0;
      if (tick) begin
        case (state)
          RX_HUNT: if (!rxd) begin
            state <= RX_START;
            sub   <= '0;
          end
          RX_START: if (mid_start) begin
            sub   <= '0;
            bitn  <= '0;
            state <= rxd ? RX_HUNT : RX_BITS;
          end else begin
            sub <= sub + 1'b1;
          end
          RX_BITS: if (bit_end) begin
            sub   <= '0;
            shreg <= {rxd, shreg[WORD_W-1:1]};
            if (bitn == 4'(CHAR_W)) state <= RX_STOP;
            else bitn <= bitn + 1'b1;
          end else begin
            sub <= sub + 1'b1;
          end
          RX_STOP: if (bit_end) begin
            sub        <= '0;
            frame_done <= rxd;
            state      <= RX_HUNT;
          end else begin
            sub <= sub + 1'b1;
          end
          default: state <= RX_HUNT;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) idle_cnt <= '0;
    else if (idle_clear || state != RX_HUNT || !rxd) idle_cnt <= '0;
    else if (tick && idle_cnt < IC_W'(IDLE_T)) idle_cnt <= idle_cnt + 1'b1;
  end

  p_idle_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    idle_cnt <= IC_W'(IDLE_T));
  p_reject_to_hunt_r9: assert property (@(posedge clk) disable iff (!rst_n)
    start_reject |=> (state == RX_HUNT));
  p_done_after_mark_r9: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> $past(rxd));
endmodule

// File: rtl/mdrop_wake.sv
module mdrop_wake
  import mdrop_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_done,
  input  logic [WORD_W-1:0] frame_word,
  input  logic              idle_hit,
  input  wake_mode_e        mode,
  input  logic              match_en,
  input  logic [CHAR_W-1:0] station,
  input  logic              sleep_req,
  input  logic              ack,
  output logic              asleep,
  output logic              full,
  output logic [WORD_W-1:0] word,
  output logic              sleep_enter
);
  logic is_addr, addr_wake, listening, reject_addr, deliver, idle_wake;

  assign is_addr     = frame_word[WORD_W-1];
  assign addr_wake   = asleep && (mode == WAKE_ADDR) && is_addr;
  assign listening   = !asleep || addr_wake;
  assign reject_addr = is_addr && match_en && (frame_word[CHAR_W-1:0] != station);
  assign deliver     = frame_done && listening && !reject_addr;
  assign sleep_enter = (frame_done && listening && reject_addr) || sleep_req;
  assign idle_wake   = asleep && (mode == WAKE_IDLE) && idle_hit;

  always_ff @(posedge clk) begin
    if (!rst_n) asleep <= 1'b0;
    else if (sleep_enter) asleep <= 1'b1;
    else if (deliver || idle_wake) asleep <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full <= 1'b0;
      word <= '0;
    end else if (deliver) begin
      full <= 1'b1;
      word <= frame_word;
    end else if (ack) begin
      full <= 1'b0;
    end
  end

  p_sleep_no_deliver_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (asleep && mode == WAKE_IDLE) |-> !deliver);
  p_addr_wake_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && asleep && mode == WAKE_ADDR && is_addr && !match_en && !sleep_req)
      |=> (!asleep && full));
  p_mismatch_sleeps_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && listening && reject_addr) |=> asleep);
  p_ack_clears_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !deliver) |=> !full);
  p_forced_sleep_r12: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_req |=> asleep);
endmodule

// File: rtl/mdrop_uart.sv
module mdrop_uart
  import mdrop_pkg::*;
#(
  parameter int DIV_W     = 16,
  parameter int OVS       = 16,
  parameter int IDLE_BITS = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DIV_W-1:0]  baud_div,
  input  logic [CHAR_W-1:0] tx_char,
  input  logic              tx_data_wr,
  input  logic              tx_addr_wr,
  input  logic              wired_mode,
  output logic              txd_out,
  output logic              txd_oe,
  output logic              tx_empty,
  input  logic              rxd,
  input  logic              wake_mode,
  input  logic              sleep_req,
  input  logic              match_en,
  input  logic [CHAR_W-1:0] station_addr,
  input  logic              rx_ack,
  output logic [WORD_W-1:0] rx_word,
  output logic              rx_full,
  output logic              rx_asleep
);
  logic              tick;
  logic              frame_done, idle_hit, start_reject, sleep_enter;
  logic [WORD_W-1:0] frame_word;
  wake_mode_e        mode;

  assign mode = wake_mode_e'(wake_mode);

  mdrop_baud #(.DIV_W(DIV_W)) u_baud (
    .clk(clk), .rst_n(rst_n), .div(baud_div), .tick(tick)
  );

  mdrop_tx #(.OVS(OVS)) u_tx (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .wr_data(tx_data_wr), .wr_addr(tx_addr_wr), .ch(tx_char),
    .wired_mode(wired_mode), .line_out(txd_out), .line_oe(txd_oe), .empty(tx_empty)
  );

  mdrop_rx #(.OVS(OVS), .IDLE_BITS(IDLE_BITS)) u_rx (
    .clk(clk), .rst_n(rst_n), .tick(tick), .rxd_async(rxd),
    .idle_clear(sleep_enter), .frame_done(frame_done), .frame_word(frame_word),
    .idle_hit(idle_hit), .start_reject(start_reject)
  );

  mdrop_wake u_wake (
    .clk(clk), .rst_n(rst_n), .frame_done(frame_done), .frame_word(frame_word),
    .idle_hit(idle_hit), .mode(mode), .match_en(match_en), .station(station_addr),
    .sleep_req(sleep_req), .ack(rx_ack), .asleep(rx_asleep), .full(rx_full),
    .word(rx_word), .sleep_enter(sleep_enter)
  );

  p_reject_no_frame_r9: assert property (@(posedge clk) disable iff (!rst_n)
    start_reject |=> !frame_done);
endmodule

// File: tb/mdrop_uart_test.sv
`timescale 1ns/1ps
module mdrop_uart_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] baud_div = 16'd1;
  logic [7:0]  tx_char = '0;
  logic        tx_data_wr = 0, tx_addr_wr = 0, wired_mode = 0;
  logic        txd_out, txd_oe, tx_empty;
  logic        bench_rxd = 1'b1, loop_en = 1'b0;
  logic        rxd;
  logic        wake_mode = 0, sleep_req = 0, match_en = 0, rx_ack = 0;
  logic [7:0]  station_addr = '0;
  logic [8:0]  rx_word;
  logic        rx_full, rx_asleep;
  logic        line;
  int total = 0, bad = 0;
  bit finished = 0;

  localparam int BIT_CLKS = 32;  // 16 ticks, one tick every 2 clocks

  always #5 clk = ~clk;

  assign line = txd_oe ? txd_out : 1'b1;
  assign rxd  = loop_en ? line : bench_rxd;

  mdrop_uart uut (
    .clk(clk), .rst_n(rst_n), .baud_div(baud_div), .tx_char(tx_char),
    .tx_data_wr(tx_data_wr), .tx_addr_wr(tx_addr_wr), .wired_mode(wired_mode),
    .txd_out(txd_out), .txd_oe(txd_oe), .tx_empty(tx_empty), .rxd(rxd),
    .wake_mode(wake_mode), .sleep_req(sleep_req), .match_en(match_en),
    .station_addr(station_addr), .rx_ack(rx_ack), .rx_word(rx_word),
    .rx_full(rx_full), .rx_asleep(rx_asleep)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [10:0] frame_of(input logic [7:0] c, input logic b9);
    logic [10:0] f;
    f[0] = 1'b0;
    for (int i = 0; i < 8; i++) f[i+1] = c[i];
    f[9] = b9;
    f[10] = 1'b1;
    return f;
  endfunction

  task automatic wait_clks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic tx_write(input logic [7:0] c, input bit addr);
    @(negedge clk);
    tx_char = c;
    if (addr) tx_addr_wr = 1'b1; else tx_data_wr = 1'b1;
    @(negedge clk);
    tx_addr_wr = 1'b0;
    tx_data_wr = 1'b0;
  endtask

  // Decode a frame at the pin; wired_bad counts samples breaking open-drain rules.
  task automatic decode(output logic [10:0] bits, output int wired_bad);
    int guard = 0;
    wired_bad = 0;
    while (line == 1'b1 && guard < 2000) begin
      @(negedge clk);
      guard++;
    end
    wait_clks(BIT_CLKS / 2 - 2);
    for (int i = 0; i < 11; i++) begin
      bits[i] = line;
      if (wired_mode && ((txd_oe && txd_out) || (txd_oe == line))) wired_bad++;
      if (i < 10) wait_clks(BIT_CLKS);
    end
  endtask

  task automatic send_char(input logic [7:0] c, input logic b9);
    logic [10:0] f;
    f = frame_of(c, b9);
    for (int i = 0; i < 11; i++) begin
      @(negedge clk);
      bench_rxd = f[i];
      wait_clks(BIT_CLKS - 1);
    end
    wait_clks(4);
  endtask

  task automatic pulse_ack();
    @(negedge clk); rx_ack = 1'b1;
    @(negedge clk); rx_ack = 1'b0;
  endtask

  task automatic pulse_sleep();
    @(negedge clk); sleep_req = 1'b1;
    @(negedge clk); sleep_req = 1'b0;
  endtask

  task automatic t_reset();
    check(tx_empty == 1'b1, "R1 tx_empty", tx_empty, 1);
    check(rx_full == 1'b0, "R1 rx_full", rx_full, 0);
    check(rx_asleep == 1'b0, "R1 rx_asleep", rx_asleep, 0);
    check(txd_oe && txd_out, "R1 line idle high", {txd_oe, txd_out}, 3);
  endtask

  task automatic t_tx_data();
    logic [10:0] bits;
    int wb, g;
    tx_write(8'hA5, 1'b0);
    check(tx_empty == 1'b0, "R10 empty falls", tx_empty, 0);
    tx_write(8'h3C, 1'b1);  // ignored, transmitter busy
    decode(bits, wb);
    check(bits == frame_of(8'hA5, 1'b0), "R2 data frame", bits, frame_of(8'hA5, 1'b0));
    g = 0;
    while (!tx_empty && g < 200) begin @(negedge clk); g++; end
    check(tx_empty == 1'b1, "R10 empty returns", tx_empty, 1);
    wait_clks(100);
    check(line == 1'b1, "R10 busy write ignored", line, 1);
  endtask

  task automatic t_tx_addr_wired();
    logic [10:0] bits;
    int wb, g;
    wired_mode = 1'b1;
    wait_clks(2);
    check(txd_oe == 1'b0, "R4 released when idle", txd_oe, 0);
    tx_write(8'h96, 1'b1);
    decode(bits, wb);
    check(bits == frame_of(8'h96, 1'b1), "R3 address frame", bits, frame_of(8'h96, 1'b1));
    check(wb == 0, "R4 open-drain drive", wb, 0);
    g = 0;
    while (!tx_empty && g < 200) begin @(negedge clk); g++; end
    wired_mode = 1'b0;
  endtask

  task automatic t_loopback();
    int g;
    loop_en = 1'b1;
    tx_write(8'h5A, 1'b1);
    g = 0;
    while (!tx_empty && g < 1000) begin @(negedge clk); g++; end
    wait_clks(4);
    check(rx_full == 1'b1, "R3 loopback full", rx_full, 1);
    check(rx_word == 9'h15A, "R3 loopback word", rx_word, 9'h15A);
    pulse_ack();
    check(rx_full == 1'b0, "R11 ack clears", rx_full, 0);
    loop_en = 1'b0;
    wait_clks(10);
  endtask

  task automatic t_glitch();
    @(negedge clk); bench_rxd = 1'b0;
    wait_clks(6);
    bench_rxd = 1'b1;
    wait_clks(400);
    check(rx_full == 1'b0, "R9 glitch rejected", rx_full, 0);
    send_char(8'h81, 1'b0);
    check(rx_full == 1'b1 && rx_word == 9'h081, "R9 recovers", rx_word, 9'h081);
    pulse_ack();
  endtask

  task automatic t_sleep_addr();
    wake_mode = 1'b1;
    pulse_sleep();
    check(rx_asleep == 1'b1, "R12 forced sleep", rx_asleep, 1);
    send_char(8'h11, 1'b0);
    check(rx_full == 1'b0, "R5 data dropped asleep", rx_full, 0);
    check(rx_asleep == 1'b1, "R5 stays asleep", rx_asleep, 1);
    send_char(8'h22, 1'b1);
    check(rx_asleep == 1'b0, "R6 address wakes", rx_asleep, 0);
    check(rx_full && rx_word == 9'h122, "R6 address delivered", rx_word, 9'h122);
    pulse_ack();
  endtask

  task automatic t_idle_wake();
    wake_mode = 1'b0;
    pulse_sleep();
    send_char(8'h44, 1'b1);
    check(rx_full == 1'b0, "R5 idle mode drops", rx_full, 0);
    wait_clks(240);
    check(rx_asleep == 1'b1, "R7 not yet idle", rx_asleep, 1);
    wait_clks(100);
    check(rx_asleep == 1'b0, "R7 idle wakes", rx_asleep, 0);
    send_char(8'h66, 1'b0);
    check(rx_full && rx_word == 9'h066, "R7 awake receives", rx_word, 9'h066);
    pulse_ack();
  endtask

  task automatic t_match();
    wake_mode = 1'b1;
    match_en = 1'b1;
    station_addr = 8'h33;
    send_char(8'h44, 1'b1);
    check(rx_asleep == 1'b1, "R8 mismatch sleeps", rx_asleep, 1);
    check(rx_full == 1'b0, "R8 mismatch dropped", rx_full, 0);
    send_char(8'h55, 1'b0);
    check(rx_full == 1'b0, "R8 other data dropped", rx_full, 0);
    send_char(8'h33, 1'b1);
    check(rx_asleep == 1'b0, "R8 match awake", rx_asleep, 0);
    check(rx_full && rx_word == 9'h133, "R8 match delivered", rx_word, 9'h133);
    pulse_ack();
    send_char(8'h77, 1'b0);
    check(rx_full && rx_word == 9'h077, "R8 message data", rx_word, 9'h077);
    pulse_ack();
    send_char(8'h44, 1'b1);
    check(rx_asleep == 1'b1, "R8 next message sleeps", rx_asleep, 1);
    match_en = 1'b0;
  endtask

  initial begin
    wait_clks(5);
    rst_n = 1'b1;
    wait_clks(3);
    t_reset();
    t_tx_data();
    t_tx_addr_wired();
    t_loopback();
    t_glitch();
    t_sleep_addr();
    t_idle_wake();
    t_match();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=0x0 expected=0x1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule